// File: doc/BRIEF.md
# Paged Address Counter and Timed Page Commit Controller

This block sits behind a two-wire serial memory protocol engine. It owns the persistent word address of a byte memory of 128 pages × 16 bytes, which is 2048 bytes on an 11-bit address. It collects the data bytes of a write sequence in a 16-entry page latch, and it performs the self-timed commit of those bytes into a synchronous RAM model once the bus master ends the sequence with a stop. The protocol engine turns bus events into one-cycle strobes: load an address, accept a data byte, fetch a read byte, and stop.

Writes and reads advance the counter differently:
- **Writes** advance only the in-page offset, so a long write sequence wraps back to the start of its own page.
- **Reads** advance the full address and wrap from the last byte of the array to byte 0.

The counter keeps its value between sequences, so a read with no address load continues where the last access stopped.

A stop with latched bytes starts a busy window whose length, `WR_CYCLES`, is counted in clock cycles. The latched bytes are copied into the RAM during that window, and every strobe is ignored until it ends. When the write-protect input is high at the stop, the pending bytes are discarded silently.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, `busy_o` is 0 and `addr_o` is 0.
- R2: A `load_i` strobe sets `addr_o` to `load_addr_i` one cycle later and discards every byte latched before it.
- R3: Each `wr_i` strobe latches `wr_data_i` at the in-page offset `addr_o[3:0]`. It then increments only `addr_o[3:0]` modulo 16 and leaves the page bits `addr_o[10:4]` unchanged.
- R4: When more than 16 bytes arrive in one sequence, a later byte replaces the earlier one latched at the same offset, and only the last value at each offset is committed.
- R5: A commit writes only the offsets received since the last load. Every other byte of the page keeps its old value.
- R6: After an `rd_i` strobe, `rd_data_o` shows the byte at the previous `addr_o` on the following cycle. The counter increments by one and wraps from 2047 to 0.
- R7: A `stop_i` with at least one latched byte and `wp_i` low raises `busy_o` on the next cycle. `busy_o` then stays high for exactly BUSY_LEN = max(`WR_CYCLES`, 16) cycles, and the committed data is readable once it falls.
- R8: A `stop_i` with `wp_i` high leaves the memory unchanged, keeps `busy_o` low, and discards the latched bytes, so a later stop commits nothing.
- R9: While `busy_o` is high, every strobe is ignored: `addr_o` and `rd_data_o` hold, and no latch update or new commit takes place.
- R10: A `stop_i` with no latched bytes, such as after a read sequence, leaves `busy_o` low.
- R11: When strobes arrive in the same cycle, the priority is load, then write, then read, then stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp_i | input | 1 | Write protect; high blocks the commit |
| load_i | input | 1 | Load-address strobe that starts a new sequence |
| load_addr_i | input | ADDR_W | Address loaded by `load_i` |
| wr_i | input | 1 | Data-byte strobe |
| wr_data_i | input | DATA_W | Byte that goes with `wr_i` |
| rd_i | input | 1 | Read-byte strobe |
| stop_i | input | 1 | Stop strobe that ends the sequence |
| busy_o | output | 1 | High during the timed commit window |
| addr_o | output | ADDR_W | Current word address counter |
| rd_data_o | output | DATA_W | Byte fetched by the last accepted read |

## Verification
The embedded properties check on every cycle the rules that act at a single cycle boundary:
- the counter holds while busy;
- write steps keep the page bits;
- a read step from the top address wraps to 0;
- RAM writes happen only inside the busy window, and that window opens only on an accepted stop;
- a protected stop never raises busy.

The bench scenarios cover what needs memory contents over whole sequences. It fills and reads back the entire array and wraps a write across a page end. It also overruns a page, leaves offsets unwritten, ignores strobes issued during busy, and shows that a protected sequence leaves no trace. All expected bytes come from an arithmetic model of the requirements.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_LOAD,
    OP_WRITE,
    OP_READ,
    OP_STOP
  } pcu_op_e;
endpackage

// File: rtl/pcu_addr_ctr.sv
module pcu_addr_ctr #(
  parameter int ADDR_W = 11,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step_wr,
  input  logic              step_rd,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (load) begin
      addr_d  = load_addr;
      addr_en = 1'b1;
    end else if (step_wr) begin
      addr_d  = {addr_q[ADDR_W-1:OFS_W], addr_q[OFS_W-1:0] + 1'b1};
      addr_en = 1'b1;
    end else if (step_rd) begin
      addr_d  = addr_q + 1'b1;
      addr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R9: the counter does not move while the commit window is open
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q));
  // R3: a write step keeps the page bits
  p_wr_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_wr && !load) |=> (addr_q[ADDR_W-1:OFS_W] == $past(addr_q[ADDR_W-1:OFS_W])));
  // R6: a read step from the top address wraps to zero
  p_rd_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rd && !load && !step_wr && (addr_q == '1)) |=> (addr_q == '0));
endmodule

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int OFS_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr,
  input  logic [OFS_W-1:0]      wr_ofs,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [OFS_W-1:0]      rd_ofs,
  output logic [PAGE_BYTES-1:0] mask_o,
  output logic [DATA_W-1:0]     data_o
);
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [DATA_W-1:0]     byte_q [PAGE_BYTES];

  always_comb begin
    mask_d = mask_q;
    if (clr)     mask_d = '0;
    else if (wr) mask_d[wr_ofs] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic slot_en;
    assign slot_en = wr && (wr_ofs == OFS_W'(i));
    always_ff @(posedge clk) begin
      if (slot_en) byte_q[i] <= wr_data;
    end
  end

  assign mask_o = mask_q;
  assign data_o = byte_q[rd_ofs];
endmodule

// File: rtl/pcu_wr_timer.sv
module pcu_wr_timer #(
  parameter int BUSY_LEN = 16,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_LEN - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);
  assign idx_o  = cnt_q;

  // R7: the window opens only on an accepted stop
  p_start_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(go));
endmodule

// File: rtl/pcu_ram.sv
module pcu_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [2**ADDR_W];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_o <= mem[raddr];
  end
endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit
  import pcu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int NUM_PAGES  = 128,
  parameter int WR_CYCLES  = 500000,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int ADDR_W    = $clog2(PAGE_BYTES * NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int BUSY_LEN = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;
  localparam int CNT_W    = $clog2(BUSY_LEN);
  localparam int PAGE_W   = ADDR_W - OFS_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic                  busy, done;
  logic [CNT_W-1:0]      wt_idx;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     walk_data;
  logic [ADDR_W-1:0]     addr;
  pcu_op_e               op;

  // strobe decode, ignored while busy (R9, R11)
  always_comb begin
    op = OP_IDLE;
    if (!busy) begin
      if (load_i)      op = OP_LOAD;
      else if (wr_i)   op = OP_WRITE;
      else if (rd_i)   op = OP_READ;
      else if (stop_i) op = OP_STOP;
    end
  end

  logic go, latch_clr, walk_act, ram_we;
  assign go        = (op == OP_STOP) && (|mask) && !wp_i;
  assign latch_clr = (op == OP_LOAD) || ((op == OP_STOP) && !go) || done;

  // page of the pending sequence, taken at the load
  logic [PAGE_W-1:0] page_q, page_d;
  always_comb begin
    page_d = page_q;
    if (op == OP_LOAD) page_d = load_addr_i[ADDR_W-1:OFS_W];
  end
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) page_q <= '0;
    else          page_q <= page_d;
  end

  pcu_addr_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .busy      (busy),
    .load      (op == OP_LOAD),
    .load_addr (load_addr_i),
    .step_wr   (op == OP_WRITE),
    .step_rd   (op == OP_READ),
    .addr_o    (addr)
  );

  pcu_page_latch #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr     (latch_clr),
    .wr      (op == OP_WRITE),
    .wr_ofs  (addr[OFS_W-1:0]),
    .wr_data (wr_data_i),
    .rd_ofs  (wt_idx[OFS_W-1:0]),
    .mask_o  (mask),
    .data_o  (walk_data)
  );

  pcu_wr_timer #(.BUSY_LEN(BUSY_LEN), .CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .go     (go),
    .busy_o (busy),
    .done_o (done),
    .idx_o  (wt_idx)
  );

  // one latched byte per cycle in the first PAGE_BYTES cycles of the window
  assign walk_act = busy && (32'(wt_idx) < PAGE_BYTES);
  assign ram_we   = walk_act && mask[wt_idx[OFS_W-1:0]];

  pcu_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   ({page_q, wt_idx[OFS_W-1:0]}),
    .wdata   (walk_data),
    .re      (op == OP_READ),
    .raddr   (addr),
    .rdata_o (rd_data_o)
  );

  assign busy_o = busy;
  assign addr_o = addr;

  // R5: the RAM is written only inside the commit window
  p_we_in_window_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    ram_we |-> busy_o);
  // R8: a protected stop never opens the window
  p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stop_i && wp_i && !busy_o) |=> !busy_o);
  // R10: a stop with nothing latched never opens the window
  p_empty_stop_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((op == OP_STOP) && (mask == '0)) |=> !busy_o);
endmodule

// File: tb/sim_page_commit_unit.sv
module sim_page_commit_unit;
  localparam int WRC  = 24;
  localparam int BLEN = 24;
  localparam int SIZE = 2048;

  logic        clk = 1'b0;
  logic        rst_n, wp_i, load_i, wr_i, rd_i, stop_i;
  logic [10:0] load_addr_i;
  logic [7:0]  wr_data_i;
  logic        busy_o;
  logic [10:0] addr_o;
  logic [7:0]  rd_data_o;

  page_commit_unit #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .load_i(load_i),
    .load_addr_i(load_addr_i), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .rd_i(rd_i), .stop_i(stop_i), .busy_o(busy_o), .addr_o(addr_o),
    .rd_data_o(rd_data_o)
  );

  always #5 clk = ~clk;

  int         n_chk = 0, n_fail = 0;
  logic [7:0] exp_mem [SIZE];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int a);
    load_i = 1'b1; load_addr_i = 11'(a);
    @(negedge clk); load_i = 1'b0;
  endtask
  task automatic do_wr(input logic [7:0] d);
    wr_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask
  task automatic do_rd;
    rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
  endtask
  task automatic do_stop;
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'(i * 29 + s * 71 + (i >> 7));
  endfunction

  // write n bytes from start; the model places them per the page-wrap rule
  task automatic seq_write(input int start, input int n, input int s, input bit apply);
    do_load(start);
    for (int i = 0; i < n; i++) begin
      do_wr(pat(i, s));
      if (apply) exp_mem[(start & ~15) | ((start + i) & 15)] = pat(i, s);
    end
  endtask

  task automatic read_at(input int a, input string req);
    do_load(a);
    do_rd;
    chk(req, rd_data_o, exp_mem[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, a0, d0;
    rst_n = 1'b0; wp_i = 1'b0; load_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0; stop_i = 1'b0;
    load_addr_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", busy_o, 0);
    chk("R1 addr at reset", addr_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy after release", busy_o, 0);
    chk("R1 addr after release", addr_o, 0);

    // fill every page, measure each commit window (R7) and the in-page wrap (R3)
    for (int p = 0; p < 128; p++) begin
      seq_write(p * 16, 16, p, 1'b1);
      chk("R3 page wrap after 16 bytes", addr_o, p * 16);
      do_stop;
      wait_idle(n);
      chk("R7 busy length", n, BLEN);
    end

    // full-array sequential read with roll-over (R6, R2)
    do_load(0);
    chk("R2 load address", addr_o, 0);
    for (int a = 0; a < SIZE; a++) begin
      chk("R6 address before read", addr_o, a);
      do_rd;
      chk("R6 sequential data", rd_data_o, exp_mem[a]);
    end
    chk("R6 roll-over to zero", addr_o, 0);
    do_rd;
    chk("R6 data after roll-over", rd_data_o, exp_mem[0]);
    // R10: stop closing a read sequence opens no window
    do_stop;
    chk("R10 no busy after read stop", busy_o, 0);
    @(negedge clk);
    chk("R10 still idle", busy_o, 0);

    // partial write across the page end (R3, R5) then current-address read (R6)
    seq_write(12'h125, 14, 200, 1'b1);
    chk("R3 offset wrapped, page kept", addr_o, 12'h123);
    do_stop;
    wait_idle(n);
    chk("R7 busy length partial", n, BLEN);
    chk("R6 counter kept across commit", addr_o, 12'h123);
    do_rd;
    chk("R6 current-address read", rd_data_o, exp_mem[12'h123]);
    chk("R6 counter after current read", addr_o, 12'h124);
    for (int o = 0; o < 16; o++) read_at(12'h120 + o, "R5 partial page contents");

    // overrun: 20 bytes into one page (R4)
    seq_write(12'h300, 20, 33, 1'b1);
    do_stop;
    wait_idle(n);
    for (int o = 0; o < 16; o++) read_at(12'h300 + o, "R4 overrun keeps last byte");
    chk("R4 offset 0 holds byte 16", exp_mem[12'h300], pat(16, 33));

    // write protect (R8)
    wp_i = 1'b1;
    seq_write(12'h400, 3, 90, 1'b0);
    do_stop;
    chk("R8 no busy when protected", busy_o, 0);
    wp_i = 1'b0;
    do_stop;
    chk("R8 pending bytes discarded", busy_o, 0);
    for (int o = 0; o < 4; o++) read_at(12'h400 + o, "R8 protected page unchanged");

    // strobes during busy are ignored (R9)
    seq_write(12'h050, 2, 55, 1'b1);
    do_stop;
    chk("R7 busy raised after stop", busy_o, 1);
    a0 = addr_o; d0 = rd_data_o;
    do_load(12'h7FF);
    do_wr(8'hAA);
    do_rd;
    do_stop;
    chk("R9 addr held while busy", addr_o, a0);
    chk("R9 read data held while busy", rd_data_o, d0);
    wait_idle(n);
    chk("R9 window unchanged by strobes", n, BLEN - 4);
    @(negedge clk);
    chk("R9 no second commit", busy_o, 0);
    chk("R9 counter after window", addr_o, 12'h052);
    for (int o = 0; o < 4; o++) read_at(12'h050 + o, "R9 ignored write left no trace");

    // simultaneous strobes: load wins over write (R11)
    load_i = 1'b1; load_addr_i = 11'h233; wr_i = 1'b1; wr_data_i = 8'h5C;
    @(negedge clk); load_i = 1'b0; wr_i = 1'b0;
    chk("R11 load wins", addr_o, 12'h233);
    do_stop;
    chk("R11 write was dropped", busy_o, 0);
    read_at(12'h233, "R11 memory unchanged");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule